// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the SCL waveform of an I2C bus master from the peripheral clock. A 16-bit control word holds three settings. A speed-mode bit selects standard or fast operation. A duty bit selects the fast-mode ratio. A 12-bit divider sets the length of one time unit in peripheral-clock cycles. From these the block counts out the low and high halves of each SCL period. It drives the line open-drain and raises a one-cycle tick at every phase boundary. The master sequencer uses the tick to move SDA while the clock is low.

The control word can be loaded only while the peripheral is disabled. Once the peripheral is enabled and the sequencer requests a run, a three-state machine takes over. Idle releases the line. Low pulls it down. High releases it and counts only while the sampled line reads high, so a slave that stretches the clock lengthens the high phase. The transitions are as follows. Idle goes to Low on a run request with the peripheral enabled. Low goes to High when the low count completes. High goes to Low when the high count completes. Any state returns to Idle when the run request or the enable drops.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, the control word reads 0x0000, scl_oe is 0 (line released) and phase_tick is 0.
- R2: A write strobe while periph_en is 0 loads the control word. Bit 15 is the mode bit (1 = fast), bit 14 is the duty bit and bits 11:0 are the divider. Bits 13:12 always read as 0. A write strobe while periph_en is 1 leaves the control word unchanged.
- R3: In standard mode (bit 15 = 0), the low phase and the high phase each last D peripheral-clock cycles, where D is the effective divider. The duty bit has no effect in this mode.
- R4: In fast mode with duty 0, the high phase lasts D cycles and the low phase lasts 2·D cycles.
- R5: In fast mode with duty 1, the high phase lasts 9·D cycles and the low phase lasts 16·D cycles.
- R6: The effective divider D is the programmed divider raised to a floor. The floor is 1 in fast mode with duty 1 and 4 in every other case. For example, divider 0 in fast mode with duty 1 gives 9 and 16 cycles, and divider 3 in standard mode gives 4 and 4.
- R7: The high-phase count advances only on cycles where scl_in is 1. The high phase ends after D·k cycles with scl_in high, where k is 1 or 9 as set by the mode, so holding scl_in low stretches the released time cycle for cycle.
- R8: When run or periph_en is 0, scl_oe is 0 from the next cycle on, whatever phase was in progress.
- R9: phase_tick is 1 for exactly the first cycle of every low phase and every high phase, and 0 on all other cycles.
- R10: From idle, scl_oe rises one cycle after run and periph_en are first both seen high, so a fresh period starts with its low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable; also locks the control word |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| run | input | 1 | Clock run request from the master sequencer |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Open-drain pull-down enable for SCL (1 = drive low) |
| phase_tick | output | 1 | One-cycle pulse in the first cycle of each phase |
| ctrl_rd | output | 16 | Current control word |

## Verification
A wrong divider floor or ratio shows at the ports as a wrong count of scl_oe cycles. The error appears within the first full SCL period after enabling, because the bench measures both phase lengths against the mode formulas. A counter that keeps advancing during stretching makes the released time too short, and this shows within one stretched high phase. A state machine that fails to return to idle leaves scl_oe asserted one cycle after run drops. A misplaced tick register shows as a tick that is missing or extra on the first cycle of a phase.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int CFG_W    = 16;
    localparam int MODE_BIT = 15;
    localparam int DUTY_BIT = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
    parameter int DIV_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     locked,
    input  logic                     wr_en,
    input  logic [scl_pkg::CFG_W-1:0] wr_data,
    output logic [scl_pkg::CFG_W-1:0] cfg_word
);
    localparam logic [scl_pkg::CFG_W-1:0] KEEP_MASK =
        (scl_pkg::CFG_W'(1) << scl_pkg::MODE_BIT) |
        (scl_pkg::CFG_W'(1) << scl_pkg::DUTY_BIT) |
        ((scl_pkg::CFG_W'(1) << DIV_W) - scl_pkg::CFG_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word <= '0;
        end else if (wr_en && !locked) begin
            cfg_word <= wr_data & KEEP_MASK;
        end
    end

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en) |=> $stable(cfg_word)); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_word[13:12] == 2'b00)); // R2
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int DIV_W = 12,
    parameter int CNT_W = DIV_W + 4
) (
    input  logic [scl_pkg::CFG_W-1:0] cfg_word,
    output logic [CNT_W-1:0]          high_len,
    output logic [CNT_W-1:0]          low_len
);
    logic             fast;
    logic             duty;
    logic [CNT_W-1:0] floor_v;
    logic [CNT_W-1:0] div_raw;
    logic [CNT_W-1:0] div_eff;

    always_comb begin
        fast    = cfg_word[scl_pkg::MODE_BIT];
        duty    = cfg_word[scl_pkg::DUTY_BIT];
        div_raw = CNT_W'(cfg_word[DIV_W-1:0]);
        floor_v = (fast && duty) ? CNT_W'(1) : CNT_W'(4);
        div_eff = (div_raw < floor_v) ? floor_v : div_raw;
        high_len = (fast && duty) ? div_eff * CNT_W'(9) : div_eff;
        if (!fast) begin
            low_len = div_eff;
        end else if (duty) begin
            low_len = div_eff << 4;
        end else begin
            low_len = div_eff << 1;
        end
    end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int DIV_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        periph_en,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        run,
    input  logic        scl_in,
    output logic        scl_oe,
    output logic        phase_tick,
    output logic [15:0] ctrl_rd
);
    import scl_pkg::*;

    localparam int CNT_W = DIV_W + 4;

    scl_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] high_len, low_len;
    logic             go;

    scl_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (periph_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_word (ctrl_rd)
    );

    scl_phase_len #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_len (
        .cfg_word (ctrl_rd),
        .high_len (high_len),
        .low_len  (low_len)
    );

    assign go = run && periph_en;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            ST_IDLE: begin
                if (go) begin
                    st_nxt  = ST_LOW;
                    cnt_nxt = '0;
                end
            end
            ST_LOW: begin
                if (cnt == low_len - CNT_W'(1)) begin
                    st_nxt  = ST_HIGH;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (scl_in) begin
                    if (cnt == high_len - CNT_W'(1)) begin
                        st_nxt  = ST_LOW;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_nxt  = ST_IDLE;
                cnt_nxt = '0;
            end
        endcase
        if (!go) begin
            st_nxt  = ST_IDLE;
            cnt_nxt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            phase_tick <= 1'b0;
        end else begin
            st         <= st_nxt;
            cnt        <= cnt_nxt;
            phase_tick <= (st_nxt != st) && (st_nxt != ST_IDLE);
        end
    end

    always_comb begin
        scl_oe = (st == ST_LOW);
    end

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !scl_oe); // R8
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |=> !phase_tick); // R9
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH && !scl_in && go) |=> (st == ST_HIGH && $stable(cnt))); // R7
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW) |-> (cnt < low_len)); // R3
    AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (high_len >= CNT_W'(4) && low_len >= CNT_W'(4))); // R6
endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        periph_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        run = 1'b0;
    logic        stretch = 1'b0;
    logic        scl_in;
    logic        scl_oe;
    logic        phase_tick;
    logic [15:0] ctrl_rd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign scl_in = !scl_oe && !stretch;

    scl_clkgen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .periph_en  (periph_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .run        (run),
        .scl_in     (scl_in),
        .scl_oe     (scl_oe),
        .phase_tick (phase_tick),
        .ctrl_rd    (ctrl_rd)
    );

    function automatic int exp_len(logic [15:0] w, bit hi);
        int  d  = int'(w[11:0]);
        bit  f  = w[15];
        bit  du = w[14];
        int  mn = (f && du) ? 1 : 4;
        if (d < mn) d = mn;
        if (hi) return (f && du) ? 9 * d : d;
        if (!f) return d;
        return du ? 16 * d : 2 * d;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(logic [15:0] w);
        @(negedge clk);
        run = 1'b0;
        periph_en = 1'b0;
        @(negedge clk);
        wr_data = w;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(ctrl_rd == (w & 16'hCFFF), "R2 load", int'(ctrl_rd), int'(w & 16'hCFFF));
        periph_en = 1'b1;
        run = 1'b1;
    endtask

    task automatic measure(output int lo, output int hi, output int tbad);
        lo = 0;
        hi = 0;
        tbad = 0;
        while (!scl_oe) @(negedge clk);
        while (scl_oe) begin
            lo++;
            if (phase_tick != (lo == 1)) tbad++;
            @(negedge clk);
        end
        while (!scl_oe) begin
            hi++;
            if (phase_tick != (hi == 1)) tbad++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(logic [15:0] w, string req);
        int lo, hi, tb;
        load(w);
        measure(lo, hi, tb);
        chk(lo == exp_len(w, 1'b0), {req, " low"}, lo, exp_len(w, 1'b0));
        chk(hi == exp_len(w, 1'b1), {req, " high"}, hi, exp_len(w, 1'b1));
        chk(tb == 0, "R9 tick", tb, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        int hcnt;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ctrl_rd == 16'h0000, "R1 word", int'(ctrl_rd), 0);
        chk(scl_oe == 1'b0, "R1 oe", int'(scl_oe), 0);
        chk(phase_tick == 1'b0, "R1 tick", int'(phase_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reserved bits and write lock
        load(16'hFFFF);
        @(negedge clk);
        wr_data = 16'h0028;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(ctrl_rd == 16'hCFFF, "R2 locked", int'(ctrl_rd), 16'hCFFF);

        // directed corners
        run_case(16'h0028, "R3 std 0x28");
        run_case(16'h4010, "R3 std duty ignored");
        run_case(16'h8006, "R4 fast duty0");
        run_case(16'hC002, "R5 fast duty1");
        run_case(16'hC000, "R6 floor fast duty1");
        run_case(16'h0003, "R6 floor std");
        run_case(16'h8000, "R6 floor fast duty0");

        // constrained random configurations
        for (int i = 0; i < 12; i++) begin
            logic [15:0] w;
            w = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
                 2'($urandom_range(3, 0)), 12'($urandom_range(40, 0))};
            run_case(w, w[15] ? (w[14] ? "R5 rand" : "R4 rand") : "R3 rand");
        end

        // R7 stretching during the high phase
        load(16'h0008);
        while (!scl_oe) @(negedge clk);
        while (scl_oe) @(negedge clk);
        hcnt = 1;
        stretch = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (!scl_oe) hcnt++;
        end
        stretch = 1'b0;
        @(negedge clk);
        while (!scl_oe) begin
            hcnt++;
            @(negedge clk);
        end
        chk(hcnt == 13, "R7 stretched high", hcnt, 13);

        // R8 run drop in low phase
        @(negedge clk);
        chk(scl_oe == 1'b1, "R8 pre low", int'(scl_oe), 1);
        run = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b0, "R8 run drop", int'(scl_oe), 0);
        repeat (3) @(negedge clk);
        chk(scl_oe == 1'b0, "R8 idle hold", int'(scl_oe), 0);

        // R10 start from idle
        run = 1'b1;
        @(negedge clk);
        chk(scl_oe == 1'b1, "R10 start low", int'(scl_oe), 1);
        chk(phase_tick == 1'b1, "R9 start tick", int'(phase_tick), 1);

        // R8 enable drop
        @(negedge clk);
        periph_en = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b0, "R8 enable drop", int'(scl_oe), 0);
        chk(phase_tick == 1'b0, "R9 idle tick", int'(phase_tick), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule